// File: doc/BRIEF.md
# Base Address Window Decoder

This block takes the address-space enable bits of a device's command register, the contents of its base address registers and of its expansion ROM register, and works out for each region whether the region is currently mapped and where it starts. Each region has a fixed power-of-two size and a fixed space type, I/O or memory, set by parameters. A region whose programmed placement breaks the validity rules is reported as unmapped. Such a placement can be a zero base, a window that runs past the top of its space, or a disabled space. An unmapped region never takes part in decoding.

The same block decodes incoming transactions. A transaction presents an address and a space type with a valid strobe. One clock later the block reports a one-hot vector that names the region the address falls into, or all zeros. When windows overlap, the region with the lowest index takes the hit. The mapped flags and bases are combinational functions of the register and command inputs. Only the hit vector is registered.

Regions are numbered 0 to NUM_BARS-1 for the base address registers, and the expansion ROM takes index NUM_BARS. The ROM region is always a memory region.

Top module: `bar_window_decoder`

## Requirements
- R1: An I/O region can be mapped only while `cmd_io_space_en` is 1. A memory region, including the ROM region, can be mapped only while `cmd_mem_space_en` is 1.
- R2: For a mapped region i, `region_base[i*ADDR_W +: ADDR_W]` equals the programmed register value with its low log2(size) bits forced to zero.
- R3: For an unmapped region, the base field reads as all ones.
- R4: An I/O region is unmapped when its aligned base is zero, or when its last address (base+size-1) is 0x10000 or higher.
- R5: A memory region is unmapped when its aligned base is zero, when its last address overflows the address width, or when its last address equals all ones (0xFFFFFFFF at the default width).
- R6: The ROM region (index NUM_BARS) also needs bit 0 of `rom_reg` set to be mapped.
- R7: A region configured as absent (size zero) is never mapped, reports an all-ones base and never hits.
- R8: One cycle after a cycle with `txn_valid`=1, `hit_onehot` bit i is 1 when region i is mapped, `txn_is_io` (1 = I/O, 0 = memory) matches the region type, and base <= `txn_addr` <= base+size-1.
- R9: When several regions qualify, only the lowest-indexed one is reported, so `hit_onehot` never has more than one bit set.
- R10: `hit_onehot` is zero after reset, and zero in the cycle after any cycle with `txn_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hit register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_io_space_en | input | 1 | Command register I/O space enable (bit 0) |
| cmd_mem_space_en | input | 1 | Command register memory space enable (bit 1) |
| bar_regs | input | NUM_BARS*ADDR_W | Base address register values, region i at [i*ADDR_W +: ADDR_W] |
| rom_reg | input | ADDR_W | Expansion ROM register, bit 0 is its enable |
| txn_valid | input | 1 | Transaction strobe |
| txn_addr | input | ADDR_W | Transaction address |
| txn_is_io | input | 1 | Transaction space: 1 = I/O, 0 = memory |
| region_mapped | output | NUM_BARS+1 | Per-region mapped flag |
| region_base | output | (NUM_BARS+1)*ADDR_W | Per-region aligned base, all ones when unmapped |
| hit_onehot | output | NUM_BARS+1 | Registered one-hot hit vector |

## Verification
The hardest situation to reach from the ports is one where several windows are valid at once and overlap, both inside the I/O space and inside the memory space. Only that situation exercises the lowest-index rule. The bench programs nested windows of both types, then probes just below, at, inside, at the end of and just past every window, under three command settings. The rejection boundaries come from a sweep of computed register patterns through every command value. These boundaries include an I/O window ending exactly at 0xFFFF against one reaching 0x10000, and a memory window touching the top address.

// File: rtl/bar_dec_pkg.sv
`timescale 1ns/1ps
package bar_dec_pkg;
   // width of one per-region size field in the parameter vectors
   localparam int SIZE_FIELD_W = 8;
   // bit of the ROM register that enables its decoding
   localparam int ROM_EN_BIT   = 0;
   // smallest legal window exponents per space
   localparam int MIN_IO_LG    = 2;
   localparam int MIN_MEM_LG   = 4;
   localparam int MIN_ROM_LG   = 1;
endpackage

// File: rtl/bar_region_eval.sv
`timescale 1ns/1ps
module bar_region_eval import bar_dec_pkg::*; #(
   parameter int ADDR_W   = 32,
   parameter int SIZE_LG  = 8,
   parameter bit PRESENT  = 1'b1,
   parameter bit IS_IO    = 1'b0,
   parameter bit IS_ROM   = 1'b0,
   parameter longint unsigned IO_LIMIT = 64'h1_0000
) (
   input  logic              io_en,
   input  logic              mem_en,
   input  logic [ADDR_W-1:0] reg_val,
   output logic              mapped,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] last
);
   localparam logic [ADDR_W:0]   SPAN     = (ADDR_W+1)'(1) << SIZE_LG;
   localparam logic [ADDR_W:0]   SPAN_M1  = SPAN - 1'b1;
   localparam logic [ADDR_W-1:0] LOW_MASK = SPAN_M1[ADDR_W-1:0];
   localparam logic [ADDR_W:0]   IO_TOP   = (ADDR_W+1)'(IO_LIMIT);

   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W:0]   end_ext;
   logic              space_on;
   logic              rom_on;
   logic              past_top;
   logic              placement_ok;

   assign aligned  = reg_val & ~LOW_MASK;
   assign end_ext  = {1'b0, aligned} + SPAN_M1;
   assign space_on = IS_IO ? io_en : mem_en;

   // the upper limit differs between the two address spaces
   generate
      if (IS_IO) begin : g_io_limit
         assign past_top = (end_ext >= IO_TOP);
      end else begin : g_mem_limit
         assign past_top = end_ext[ADDR_W] || (end_ext[ADDR_W-1:0] == {ADDR_W{1'b1}});
      end
      if (IS_ROM) begin : g_rom_gate
         assign rom_on = reg_val[ROM_EN_BIT];
      end else begin : g_no_rom_gate
         assign rom_on = 1'b1;
      end
   endgenerate

   assign placement_ok = (aligned != '0) && !end_ext[ADDR_W] && !past_top;
   assign mapped = PRESENT && space_on && rom_on && placement_ok;
   assign base   = mapped ? aligned : {ADDR_W{1'b1}};
   assign last   = mapped ? end_ext[ADDR_W-1:0] : {ADDR_W{1'b1}};
endmodule

// File: rtl/bar_hit_select.sv
`timescale 1ns/1ps
module bar_hit_select #(
   parameter int NUM_REG = 7,
   parameter int ADDR_W  = 32,
   parameter logic [NUM_REG-1:0] REG_IO = '0
) (
   input  logic [NUM_REG-1:0]        mapped,
   input  logic [NUM_REG*ADDR_W-1:0] base,
   input  logic [NUM_REG*ADDR_W-1:0] last,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      is_io,
   output logic [NUM_REG-1:0]        hit
);
   logic [NUM_REG-1:0] cand;

   for (genvar i = 0; i < NUM_REG; i++) begin : g_cmp
      logic [ADDR_W-1:0] lo;
      logic [ADDR_W-1:0] hi;
      assign lo = base[i*ADDR_W +: ADDR_W];
      assign hi = last[i*ADDR_W +: ADDR_W];
      assign cand[i] = mapped[i] && (REG_IO[i] == is_io) && (addr >= lo) && (addr <= hi);
   end

   // isolate the lowest set bit: lowest index has priority
   assign hit = cand & (~cand + 1'b1);
endmodule

// File: rtl/bar_window_decoder.sv
`timescale 1ns/1ps
module bar_window_decoder import bar_dec_pkg::*; #(
   parameter int ADDR_W   = 32,
   parameter int NUM_BARS = 6,
   parameter logic [NUM_BARS*SIZE_FIELD_W-1:0] BAR_SIZE_LG =
      {8'd20, 8'd4, 8'd4, 8'd0, 8'd12, 8'd8},
   parameter logic [NUM_BARS-1:0] BAR_PRESENT = 6'b111011,
   parameter logic [NUM_BARS-1:0] BAR_IS_IO   = 6'b010001,
   parameter bit ROM_PRESENT = 1'b1,
   parameter int ROM_SIZE_LG = 16,
   parameter longint unsigned IO_LIMIT = 64'h1_0000
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cmd_io_space_en,
   input  logic                               cmd_mem_space_en,
   input  logic [NUM_BARS*ADDR_W-1:0]         bar_regs,
   input  logic [ADDR_W-1:0]                  rom_reg,
   input  logic                               txn_valid,
   input  logic [ADDR_W-1:0]                  txn_addr,
   input  logic                               txn_is_io,
   output logic [NUM_BARS:0]                  region_mapped,
   output logic [(NUM_BARS+1)*ADDR_W-1:0]     region_base,
   output logic [NUM_BARS:0]                  hit_onehot
);
   localparam int NUM_REG = NUM_BARS + 1;
   localparam int ROM_IDX = NUM_BARS;
   localparam logic [NUM_REG-1:0] REG_IO = {1'b0, BAR_IS_IO};

   // elaboration-time parameter checks
   if (ADDR_W < 17 || ADDR_W > 63) begin : g_bad_width
      $error("bar_window_decoder: ADDR_W out of range");
   end
   if (NUM_BARS < 1 || NUM_BARS > 6) begin : g_bad_count
      $error("bar_window_decoder: NUM_BARS must be 1..6");
   end
   if (ROM_PRESENT && (ROM_SIZE_LG < MIN_ROM_LG || ROM_SIZE_LG >= ADDR_W)) begin : g_bad_rom
      $error("bar_window_decoder: ROM size out of range");
   end

   logic [NUM_REG*ADDR_W-1:0] region_last;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam int LG = int'(BAR_SIZE_LG[i*SIZE_FIELD_W +: SIZE_FIELD_W]);
      if (BAR_PRESENT[i] && BAR_IS_IO[i] && (LG < MIN_IO_LG || LG > 16)) begin : g_bad_io
         $error("bar_window_decoder: I/O region size out of range");
      end
      if (BAR_PRESENT[i] && !BAR_IS_IO[i] && (LG < MIN_MEM_LG || LG >= ADDR_W)) begin : g_bad_mem
         $error("bar_window_decoder: memory region size out of range");
      end
      bar_region_eval #(
         .ADDR_W   (ADDR_W),
         .SIZE_LG  (LG),
         .PRESENT  (BAR_PRESENT[i]),
         .IS_IO    (BAR_IS_IO[i]),
         .IS_ROM   (1'b0),
         .IO_LIMIT (IO_LIMIT)
      ) u_eval (
         .io_en   (cmd_io_space_en),
         .mem_en  (cmd_mem_space_en),
         .reg_val (bar_regs[i*ADDR_W +: ADDR_W]),
         .mapped  (region_mapped[i]),
         .base    (region_base[i*ADDR_W +: ADDR_W]),
         .last    (region_last[i*ADDR_W +: ADDR_W])
      );
   end

   bar_region_eval #(
      .ADDR_W   (ADDR_W),
      .SIZE_LG  (ROM_SIZE_LG),
      .PRESENT  (ROM_PRESENT),
      .IS_IO    (1'b0),
      .IS_ROM   (1'b1),
      .IO_LIMIT (IO_LIMIT)
   ) u_rom_eval (
      .io_en   (cmd_io_space_en),
      .mem_en  (cmd_mem_space_en),
      .reg_val (rom_reg),
      .mapped  (region_mapped[ROM_IDX]),
      .base    (region_base[ROM_IDX*ADDR_W +: ADDR_W]),
      .last    (region_last[ROM_IDX*ADDR_W +: ADDR_W])
   );

   logic [NUM_REG-1:0] hit_raw;

   bar_hit_select #(
      .NUM_REG (NUM_REG),
      .ADDR_W  (ADDR_W),
      .REG_IO  (REG_IO)
   ) u_select (
      .mapped (region_mapped),
      .base   (region_base),
      .last   (region_last),
      .addr   (txn_addr),
      .is_io  (txn_is_io),
      .hit    (hit_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_onehot <= '0;
      end else begin
         hit_onehot <= txn_valid ? hit_raw : '0;
      end
   end
endmodule

// File: rtl/bar_window_decoder_chk.sv
`timescale 1ns/1ps
module bar_window_decoder_chk #(
   parameter int NUM_REG = 7,
   parameter int ROM_IDX = 6,
   parameter int ADDR_W  = 32,
   parameter logic [NUM_REG-1:0] REG_IO = '0
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      txn_valid,
   input logic                      io_en,
   input logic                      mem_en,
   input logic                      rom_on,
   input logic [NUM_REG-1:0]        mapped,
   input logic [NUM_REG*ADDR_W-1:0] base,
   input logic [NUM_REG-1:0]        hit
);
   a_r9_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> (hit == '0));

   a_r6_rom_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_on |-> !mapped[ROM_IDX]);

   for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      a_r3_unmapped_base: assert property (@(posedge clk) disable iff (!rst_n)
         !mapped[i] |-> (base[i*ADDR_W +: ADDR_W] == {ADDR_W{1'b1}}));

      a_r8_hit_needs_map: assert property (@(posedge clk) disable iff (!rst_n)
         hit[i] |-> $past(mapped[i]));

      if (REG_IO[i]) begin : g_io
         a_r1_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !io_en |-> !mapped[i]);
      end else begin : g_mem
         a_r1_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_en |-> !mapped[i]);
      end
   end
endmodule

bind bar_window_decoder bar_window_decoder_chk #(
   .NUM_REG (NUM_REG),
   .ROM_IDX (ROM_IDX),
   .ADDR_W  (ADDR_W),
   .REG_IO  (REG_IO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .txn_valid (txn_valid),
   .io_en     (cmd_io_space_en),
   .mem_en    (cmd_mem_space_en),
   .rom_on    (rom_reg[0]),
   .mapped    (region_mapped),
   .base      (region_base),
   .hit       (hit_onehot)
);

// File: tb/tb_bar_window_decoder.sv
`timescale 1ns/1ps
module tb_bar_window_decoder;
   localparam int NR = 7;
   localparam int LG   [NR] = '{8, 12, 0, 4, 4, 20, 16};
   localparam bit PRES [NR] = '{1, 1, 0, 1, 1, 1, 1};
   localparam bit ISIO [NR] = '{1, 0, 0, 0, 1, 0, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_en = 1'b0;
   logic        mem_en = 1'b0;
   logic [191:0] bar_regs = '0;
   logic [31:0] rom_reg = '0;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_is_io = 1'b0;
   logic [6:0]  region_mapped;
   logic [223:0] region_base;
   logic [6:0]  hit_onehot;

   logic [31:0] cfg [NR];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bar_window_decoder dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_io_space_en(io_en), .cmd_mem_space_en(mem_en),
      .bar_regs(bar_regs), .rom_reg(rom_reg),
      .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_is_io(txn_is_io),
      .region_mapped(region_mapped), .region_base(region_base),
      .hit_onehot(hit_onehot)
   );

   task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic longint unsigned raw_base(int i);
      longint unsigned span = 64'd1 << LG[i];
      return {32'd0, cfg[i]} & ~(span - 1);
   endfunction

   function automatic bit exp_mapped(int i);
      longint unsigned span = 64'd1 << LG[i];
      longint unsigned b = raw_base(i);
      longint unsigned l = b + span - 1;
      if (!PRES[i]) return 1'b0;
      if (ISIO[i]) begin
         if (!io_en || b == 0 || l >= 64'h1_0000) return 1'b0;
      end else begin
         if (!mem_en || b == 0 || l >= 64'hFFFF_FFFF) return 1'b0;
         if (i == 6 && !cfg[i][0]) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic string map_tag(int i);
      if (!PRES[i]) return "R7";
      if (ISIO[i] ? !io_en : !mem_en) return "R1";
      if (i == 6) return "R6";
      return ISIO[i] ? "R4" : "R5";
   endfunction

   function automatic logic [31:0] pat(int k, int i);
      case (k)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h0000_FF01;
         3: return 32'h0001_0001;
         4: return 32'hFFF0_0001;
         5: return 32'h0000_0011;
         6: return 32'hFFFF_F001;
         7: return 32'h8000_0001;
         8: return 32'h0000_FFF1;
         default: return (32'(k) * 32'h9E37_79B9) ^ (32'(i) * 32'h0101_0101) ^ 32'(k & 1);
      endcase
   endfunction

   task automatic apply_cfg();
      for (int i = 0; i < 6; i++) bar_regs[i*32 +: 32] = cfg[i];
      rom_reg = cfg[6];
   endtask

   task automatic check_regions();
      for (int i = 0; i < NR; i++) begin
         bit m = exp_mapped(i);
         longint unsigned eb = m ? raw_base(i) : 64'hFFFF_FFFF;
         chk(region_mapped[i] == m, map_tag(i), region_mapped[i], m);
         chk(region_base[i*32 +: 32] == eb[31:0], m ? "R2" : "R3",
             region_base[i*32 +: 32], eb);
      end
   endtask

   task automatic probe(longint unsigned a, bit io, bit own_absent);
      logic [6:0] exp = '0;
      int ncand = 0;
      for (int i = 0; i < NR; i++) begin
         longint unsigned span = 64'd1 << LG[i];
         longint unsigned b = raw_base(i);
         if (exp_mapped(i) && ISIO[i] == io && a >= b && a <= b + span - 1) begin
            if (ncand == 0) exp[i] = 1'b1;
            ncand++;
         end
      end
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a[31:0]; txn_is_io = io;
      @(negedge clk);
      txn_valid = 1'b0;
      chk(hit_onehot == exp, ncand > 1 ? "R9" : (own_absent ? "R7" : "R8"), hit_onehot, exp);
      @(negedge clk);
      chk(hit_onehot == 7'd0, "R10", hit_onehot, 0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) cfg[i] = '0;
      apply_cfg();
      repeat (3) @(negedge clk);
      chk(hit_onehot == 7'd0, "R10", hit_onehot, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hit_onehot == 7'd0, "R10", hit_onehot, 0);

      // sweep of register patterns under every command combination
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            io_en = c[0]; mem_en = c[1];
            for (int i = 0; i < NR; i++) cfg[i] = pat(k, i);
            apply_cfg();
            #1;
            check_regions();
         end
      end

      // nested windows in both spaces, probed around every edge
      cfg[0] = 32'h0000_1001; cfg[1] = 32'h0010_1000; cfg[2] = 32'h0000_5000;
      cfg[3] = 32'h0018_0000; cfg[4] = 32'h0000_1081; cfg[5] = 32'h0010_0000;
      cfg[6] = 32'h0010_0001;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         io_en = (c != 2); mem_en = (c != 1);
         apply_cfg();
         #1;
         check_regions();
         for (int i = 0; i < NR; i++) begin
            longint unsigned span = 64'd1 << LG[i];
            longint unsigned b = raw_base(i);
            for (int io = 0; io < 2; io++) begin
               probe(b - 1, io[0], !PRES[i]);
               probe(b, io[0], !PRES[i]);
               probe(b + span / 2, io[0], !PRES[i]);
               probe(b + span - 1, io[0], !PRES[i]);
               probe(b + span, io[0], !PRES[i]);
            end
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule